// File: doc/BRIEF.md
# Coincidence Chain Controller

This block watches one trigger line per detector module arranged on a ring. The first trigger from a free module opens a coincidence window, and every module on the ring shares that window. Any module that fires while the window is open is captured. When the window closes, the block evaluates the captured set in one cycle. If exactly two modules fired and they sit roughly opposite each other on the ring, the block binds them into a readout chain. Both modules become busy, the chain takes the next event number, and a read-enable pulse goes to the two modules. Any other outcome sends a reset pulse to every captured module, so those modules can take part in the next coincidence straight away.

Up to `N_SLOT` chains can be active at the same time, and each one is tracked in its own slot. A chain holds its modules busy until the slot's done input releases them. Triggers from busy modules are masked. The modules that are still free stay armed, so new chains can form while older chains are still being read out.

Top module: `coinc_chain_ctrl`

## Requirements
- R1: After reset, `busy`, `rd_en`, `fe_reset`, `chain_start`, `evt_num`, `pair_lo` and `pair_hi` are all zero.
- R2: A trigger from a free module, sampled at a rising edge while no window is open, opens a window that spans `WIN_CYC` sampling edges, counting the opening edge. Free triggers at any of those edges are captured. A trigger at the edge right after the window (the evaluation edge) is dropped, and it does not open a new window.
- R3: The decision outputs become visible at the edge after the last window edge. `rd_en`, `fe_reset` and `chain_start` are single-cycle pulses.
- R4: A pair is accepted when the ring distance r = min(d, N_MOD-d), with d = hi-lo, satisfies r >= N_MOD/2 - ACC_SPAN. With the defaults (16 modules, span 2) exactly 40 of the 120 pairs are accepted.
- R5: An accepted pair with a free slot forms a chain. `rd_en` pulses with exactly the two module bits. Both bits of `busy` set. `chain_start` pulses one-hot at bit s of the lowest-numbered free slot. `pair_lo` and `pair_hi` give the lower and higher module index.
- R6: A capture of one module, of three or more modules, or of a pair outside the geometry forms no chain. `fe_reset` pulses with exactly the captured module bits, and `busy` is unchanged.
- R7: `evt_num` is an `EVT_W`-bit number that starts at 0 and increases by one for each chain formed. It wraps from 2^EVT_W-1 to 0 and is valid while `chain_start` is high.
- R8: Triggers from busy modules are not captured. They neither open a window nor appear in `fe_reset` or `rd_en`.
- R9: A one-cycle pulse on `slot_done[s]` clears the busy bits of both modules in slot s at the next edge, frees that slot, and leaves the other slots untouched.
- R10: An accepted pair that finds every slot occupied is rejected as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | N_MOD | Module trigger pulses |
| slot_done | input | N_SLOT | Per-slot readout finished pulse |
| busy | output | N_MOD | Module is bound into an active chain |
| rd_en | output | N_MOD | Read-enable pulse to the chained modules |
| fe_reset | output | N_MOD | Reset pulse to rejected captured modules |
| chain_start | output | N_SLOT | One-hot pulse naming the slot just filled |
| evt_num | output | EVT_W | Event number of the chain just formed |
| pair_lo | output | $clog2(N_MOD) | Lower module index of the chain just formed |
| pair_hi | output | $clog2(N_MOD) | Higher module index of the chain just formed |

## Verification
The properties expect reset to be applied before the first trigger. The event-number check counts chain starts from that reset. The properties also take the ring numbering as the geometry reference. They place no demands on `trig` or `slot_done`: overlapping triggers, triggers from busy modules and done pulses for empty slots are all legal. The stimulus drives single-cycle trigger pulses on falling edges and raises done only for slots that the bench knows are occupied, so every release it checks is well defined.

// File: rtl/cc_pkg.sv
package cc_pkg;

  typedef enum logic [1:0] {
    CC_IDLE = 2'd0,
    CC_OPEN = 2'd1,
    CC_EVAL = 2'd2
  } cc_state_e;

  // Ring-distance acceptance test for two module indices on a ring of n_mod.
  function automatic logic cc_span_ok(input int lo, input int hi,
                                      input int n_mod, input int span);
    int d;
    int r;
    d = hi - lo;
    r = (d < n_mod - d) ? d : n_mod - d;
    return (r >= (n_mod / 2) - span);
  endfunction

endpackage

// File: rtl/cc_trig_window.sv
module cc_trig_window
  import cc_pkg::*;
#(
  parameter int N_MOD   = 16,
  parameter int WIN_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_MOD-1:0] trig,
  input  logic [N_MOD-1:0] busy,
  output logic [N_MOD-1:0] captured,
  output logic             eval_now
);

  localparam int CNT_W = $clog2(WIN_CYC + 1);

  cc_state_e        st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [N_MOD-1:0] cap_q, cap_n;
  logic [N_MOD-1:0] armed;
  logic             st_en, cnt_en, cap_en;

  assign armed = trig & ~busy;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    cap_n = cap_q;
    unique case (st_q)
      CC_IDLE: begin
        if (|armed) begin
          st_n  = CC_OPEN;
          cap_n = armed;
          cnt_n = CNT_W'(WIN_CYC - 1);
        end
      end
      CC_OPEN: begin
        cap_n = cap_q | armed;
        if (cnt_q == CNT_W'(1)) begin
          st_n = CC_EVAL;
        end else begin
          cnt_n = cnt_q - CNT_W'(1);
        end
      end
      CC_EVAL: begin
        st_n  = CC_IDLE;
        cap_n = '0;
      end
      default: begin
        st_n  = CC_IDLE;
        cap_n = '0;
      end
    endcase
  end

  assign st_en  = (st_n != st_q);
  assign cnt_en = (st_q != CC_EVAL);
  assign cap_en = (cap_n != cap_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CC_IDLE;
      cnt_q <= '0;
      cap_q <= '0;
    end else begin
      if (st_en)  st_q  <= st_n;
      if (cnt_en) cnt_q <= cnt_n;
      if (cap_en) cap_q <= cap_n;
    end
  end

  assign captured = cap_q;
  assign eval_now = (st_q == CC_EVAL);

endmodule

// File: rtl/cc_pair_judge.sv
module cc_pair_judge
  import cc_pkg::*;
#(
  parameter int N_MOD    = 16,
  parameter int ACC_SPAN = 2,
  localparam int IDX_W   = $clog2(N_MOD)
) (
  input  logic [N_MOD-1:0] captured,
  output logic             pair_ok,
  output logic [IDX_W-1:0] lo_idx,
  output logic [IDX_W-1:0] hi_idx
);

  logic two_hit;
  logic geo_ok;

  always_comb begin
    lo_idx = '0;
    for (int i = N_MOD - 1; i >= 0; i--) begin
      if (captured[i]) lo_idx = IDX_W'(i);
    end
  end

  always_comb begin
    hi_idx = '0;
    for (int i = 0; i < N_MOD; i++) begin
      if (captured[i]) hi_idx = IDX_W'(i);
    end
  end

  assign two_hit = ($countones(captured) == 2);
  assign geo_ok  = cc_span_ok(int'(lo_idx), int'(hi_idx), N_MOD, ACC_SPAN);
  assign pair_ok = two_hit & geo_ok;

endmodule

// File: rtl/cc_chain_slots.sv
module cc_chain_slots #(
  parameter int N_MOD  = 16,
  parameter int N_SLOT = 4,
  parameter int EVT_W  = 9,
  localparam int IDX_W = $clog2(N_MOD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_now,
  input  logic [N_MOD-1:0]  captured,
  input  logic              pair_ok,
  input  logic [IDX_W-1:0]  lo_idx,
  input  logic [IDX_W-1:0]  hi_idx,
  input  logic [N_SLOT-1:0] slot_done,
  output logic [N_MOD-1:0]  busy,
  output logic [N_MOD-1:0]  rd_en,
  output logic [N_MOD-1:0]  fe_reset,
  output logic [N_SLOT-1:0] chain_start,
  output logic [EVT_W-1:0]  evt_num,
  output logic [IDX_W-1:0]  pair_lo,
  output logic [IDX_W-1:0]  pair_hi
);

  logic [N_SLOT-1:0] vld_q, vld_n;
  logic [N_MOD-1:0]  mask_q [N_SLOT];
  logic [N_SLOT-1:0] pick;
  logic              have_free, accept, reject;
  logic [N_MOD-1:0]  released;
  logic [N_MOD-1:0]  busy_q, busy_n;
  logic [N_MOD-1:0]  rd_q, fe_q;
  logic [N_SLOT-1:0] start_q;
  logic [EVT_W-1:0]  evt_cnt_q, evt_q;
  logic [IDX_W-1:0]  lo_q, hi_q;

  // Lowest-numbered free slot.
  always_comb begin
    pick = '0;
    for (int s = N_SLOT - 1; s >= 0; s--) begin
      if (!vld_q[s]) begin
        pick    = '0;
        pick[s] = 1'b1;
      end
    end
  end

  assign have_free = |pick;
  assign accept    = eval_now & pair_ok & have_free;
  assign reject    = eval_now & ~accept & (|captured);

  always_comb begin
    released = '0;
    for (int s = 0; s < N_SLOT; s++) begin
      if (slot_done[s] && vld_q[s]) released = released | mask_q[s];
    end
  end

  assign vld_n  = (vld_q & ~slot_done) | (accept ? pick : '0);
  assign busy_n = (busy_q & ~released) | (accept ? captured : '0);

  // Per-slot module mask registers, loaded only when that slot is picked.
  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    logic load_en;
    assign load_en = accept & pick[s];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[s] <= '0;
      end else if (load_en) begin
        mask_q[s] <= captured;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= '0;
      busy_q  <= '0;
      rd_q    <= '0;
      fe_q    <= '0;
      start_q <= '0;
    end else begin
      vld_q   <= vld_n;
      busy_q  <= busy_n;
      rd_q    <= accept ? captured : '0;
      fe_q    <= reject ? captured : '0;
      start_q <= accept ? pick : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_cnt_q <= '0;
      evt_q     <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
    end else if (accept) begin
      evt_cnt_q <= evt_cnt_q + EVT_W'(1);
      evt_q     <= evt_cnt_q;
      lo_q      <= lo_idx;
      hi_q      <= hi_idx;
    end
  end

  assign busy        = busy_q;
  assign rd_en       = rd_q;
  assign fe_reset    = fe_q;
  assign chain_start = start_q;
  assign evt_num     = evt_q;
  assign pair_lo     = lo_q;
  assign pair_hi     = hi_q;

endmodule

// File: rtl/coinc_chain_ctrl.sv
module coinc_chain_ctrl #(
  parameter int N_MOD    = 16,
  parameter int WIN_CYC  = 4,
  parameter int N_SLOT   = 4,
  parameter int EVT_W    = 9,
  parameter int ACC_SPAN = 2,
  localparam int IDX_W   = $clog2(N_MOD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_MOD-1:0]  trig,
  input  logic [N_SLOT-1:0] slot_done,
  output logic [N_MOD-1:0]  busy,
  output logic [N_MOD-1:0]  rd_en,
  output logic [N_MOD-1:0]  fe_reset,
  output logic [N_SLOT-1:0] chain_start,
  output logic [EVT_W-1:0]  evt_num,
  output logic [IDX_W-1:0]  pair_lo,
  output logic [IDX_W-1:0]  pair_hi
);

  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic [N_MOD-1:0] captured;
  logic             eval_now;
  logic             pair_ok;
  logic [IDX_W-1:0] lo_idx, hi_idx;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  cc_trig_window #(.N_MOD(N_MOD), .WIN_CYC(WIN_CYC)) u_win (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .trig     (trig),
    .busy     (busy),
    .captured (captured),
    .eval_now (eval_now)
  );

  cc_pair_judge #(.N_MOD(N_MOD), .ACC_SPAN(ACC_SPAN)) u_judge (
    .captured (captured),
    .pair_ok  (pair_ok),
    .lo_idx   (lo_idx),
    .hi_idx   (hi_idx)
  );

  cc_chain_slots #(.N_MOD(N_MOD), .N_SLOT(N_SLOT), .EVT_W(EVT_W)) u_slots (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .eval_now    (eval_now),
    .captured    (captured),
    .pair_ok     (pair_ok),
    .lo_idx      (lo_idx),
    .hi_idx      (hi_idx),
    .slot_done   (slot_done),
    .busy        (busy),
    .rd_en       (rd_en),
    .fe_reset    (fe_reset),
    .chain_start (chain_start),
    .evt_num     (evt_num),
    .pair_lo     (pair_lo),
    .pair_hi     (pair_hi)
  );

endmodule

// File: rtl/coinc_chain_ctrl_chk.sv
module coinc_chain_ctrl_chk #(
  parameter int N_MOD    = 16,
  parameter int N_SLOT   = 4,
  parameter int EVT_W    = 9,
  parameter int ACC_SPAN = 2,
  localparam int IDX_W   = $clog2(N_MOD)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_MOD-1:0]  busy,
  input logic [N_MOD-1:0]  rd_en,
  input logic [N_MOD-1:0]  fe_reset,
  input logic [N_SLOT-1:0] chain_start,
  input logic [EVT_W-1:0]  evt_num,
  input logic [IDX_W-1:0]  pair_lo,
  input logic [IDX_W-1:0]  pair_hi
);

  logic [EVT_W-1:0] seen_chains;
  int               gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               seen_chains <= '0;
    else if (|chain_start)    seen_chains <= seen_chains + EVT_W'(1);
  end

  assign gap = int'(pair_hi) - int'(pair_lo);

  // R5
  one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chain_start));

  // R5
  rd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|chain_start) |-> ($countones(rd_en) == 2 && rd_en[pair_lo] && rd_en[pair_hi]));

  // R3
  rd_only_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_start == '0) |-> (rd_en == '0));

  // R6
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en & fe_reset) == '0);

  // R6
  reset_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_reset & busy) == '0);

  // R5
  rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en & busy) == rd_en);

  // R7
  evt_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|chain_start) |-> (evt_num == seen_chains));

  // R4
  geom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|chain_start) |-> (gap >= (N_MOD / 2) - ACC_SPAN && gap <= (N_MOD / 2) + ACC_SPAN));

  // R3
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|chain_start) |=> (chain_start == '0));

endmodule

bind coinc_chain_ctrl coinc_chain_ctrl_chk #(
  .N_MOD(N_MOD), .N_SLOT(N_SLOT), .EVT_W(EVT_W), .ACC_SPAN(ACC_SPAN)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .rd_en       (rd_en),
  .fe_reset    (fe_reset),
  .chain_start (chain_start),
  .evt_num     (evt_num),
  .pair_lo     (pair_lo),
  .pair_hi     (pair_hi)
);

// File: tb/coinc_chain_ctrl_test.sv
module coinc_chain_ctrl_test;

  localparam int N     = 16;
  localparam int WIN   = 4;
  localparam int NS    = 4;
  localparam int EW    = 9;
  localparam int SPAN  = 2;
  localparam int IW    = $clog2(N);

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  trig;
  logic [NS-1:0] slot_done;
  logic [N-1:0]  busy, rd_en, fe_reset;
  logic [NS-1:0] chain_start;
  logic [EW-1:0] evt_num;
  logic [IW-1:0] pair_lo, pair_hi;

  int checks;
  int failures;
  logic [EW-1:0] exp_evt;
  bit finished;

  coinc_chain_ctrl #(.N_MOD(N), .WIN_CYC(WIN), .N_SLOT(NS), .EVT_W(EW), .ACC_SPAN(SPAN)) uut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .slot_done(slot_done),
    .busy(busy), .rd_en(rd_en), .fe_reset(fe_reset), .chain_start(chain_start),
    .evt_num(evt_num), .pair_lo(pair_lo), .pair_hi(pair_hi)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit geo(input int i, input int j);
    int d;
    int r;
    d = j - i;
    r = (d < N - d) ? d : N - d;
    return r >= (N / 2) - SPAN;
  endfunction

  function automatic logic [N-1:0] bit2(input int i, input int j);
    logic [N-1:0] m;
    m = '0;
    m[i] = 1'b1;
    m[j] = 1'b1;
    return m;
  endfunction

  // Drive a at the first falling edge and b gap cycles later; end at the
  // falling edge after the decision edge.
  task automatic fire(input logic [N-1:0] a, input logic [N-1:0] b, input int gap);
    for (int c = 0; c <= WIN; c++) begin
      @(negedge clk);
      trig = (c == 0 ? a : '0) | (c == gap ? b : '0);
    end
    @(negedge clk);
    trig = '0;
  endtask

  task automatic release_slot(input int s);
    @(negedge clk);
    slot_done = '0;
    slot_done[s] = 1'b1;
    @(negedge clk);
    slot_done = '0;
  endtask

  task automatic expect_chain(input string tag, input int i, input int j, input int slot);
    logic [NS-1:0] sl;
    sl = '0;
    sl[slot] = 1'b1;
    chk({tag, " R5 rd_en"}, 64'(rd_en), 64'(bit2(i, j)));
    chk({tag, " R5 start"}, 64'(chain_start), 64'(sl));
    chk({tag, " R5 pair"}, 64'({pair_lo, pair_hi}), 64'({IW'(i), IW'(j)}));
    chk({tag, " R7 evt"}, 64'(evt_num), 64'(exp_evt));
    exp_evt = exp_evt + EW'(1);
  endtask

  initial begin
    int valid_cnt;
    logic [N-1:0] held;
    checks = 0;
    failures = 0;
    exp_evt = '0;
    finished = 0;
    trig = '0;
    slot_done = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1
    chk("R1 reset outputs", 64'({busy, rd_en, fe_reset}), 64'(0));
    chk("R1 reset start/evt", 64'({chain_start, evt_num, pair_lo, pair_hi}), 64'(0));

    // R4/R5/R6: sweep every pair
    valid_cnt = 0;
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        fire(bit2(i, j), '0, 0);
        if (geo(i, j)) begin
          valid_cnt++;
          expect_chain("sweep", i, j, 0);
          chk("sweep R5 busy", 64'(busy), 64'(bit2(i, j)));
          release_slot(0);
          chk("sweep R3 pulse ends", 64'({rd_en, chain_start}), 64'(0));
          chk("sweep R9 released", 64'(busy), 64'(0));
        end else begin
          chk("sweep R6 fe_reset", 64'(fe_reset), 64'(bit2(i, j)));
          chk("sweep R6 no chain", 64'({rd_en, chain_start, busy}), 64'(0));
          @(negedge clk);
          chk("sweep R3 reset pulse ends", 64'(fe_reset), 64'(0));
        end
      end
    end
    chk("R4 accepted pair count", 64'(valid_cnt), 64'(40));

    // R6: single and triple captures
    fire(16'h0001 << 5, '0, 0);
    chk("R6 single", 64'({fe_reset, rd_en}), 64'({16'h0020, 16'h0000}));
    fire(bit2(0, 8) | 16'h0200, '0, 0);
    chk("R6 triple", 64'({fe_reset, rd_en, chain_start}), 64'({16'h0301, 16'h0000, 4'h0}));

    // R2: partner on the last window edge is captured
    fire(16'h0001, 16'h0100, WIN - 1);
    expect_chain("R2 late", 0, 8, 0);
    release_slot(0);

    // R2: partner on the evaluation edge is dropped
    fire(16'h0001, 16'h0100, WIN);
    chk("R2 eval-edge drop", 64'({fe_reset, rd_en}), 64'({16'h0001, 16'h0000}));
    held = '0;
    for (int c = 0; c < WIN + 4; c++) begin
      @(negedge clk);
      held = held | fe_reset | rd_en;
    end
    chk("R2 no new window", 64'(held), 64'(0));

    // R8: busy module masked
    fire(bit2(0, 8), '0, 0);
    expect_chain("R8 setup", 0, 8, 0);
    fire(bit2(0, 9), '0, 0);
    chk("R8 masked", 64'({fe_reset, rd_en, busy}), 64'({16'h0200, 16'h0000, 16'h0101}));
    fire(16'h0100, '0, 0);
    chk("R8 busy alone no window", 64'({fe_reset, rd_en}), 64'(0));
    release_slot(0);

    // R10 and R9: fill all slots, reject, release one, accept
    for (int k = 0; k < NS; k++) begin
      fire(bit2(k, k + 8), '0, 0);
      expect_chain("R10 fill", k, k + 8, k);
    end
    fire(bit2(4, 12), '0, 0);
    chk("R10 full reject", 64'({fe_reset, rd_en, chain_start}), 64'({bit2(4, 12), 16'h0000, 4'h0}));
    release_slot(1);
    chk("R9 slot1 release", 64'(busy), 64'(16'h0D0D));
    fire(bit2(4, 12), '0, 0);
    expect_chain("R9 reuse slot1", 4, 12, 1);
    for (int k = 0; k < NS; k++) release_slot(k);
    chk("R9 all released", 64'(busy), 64'(0));

    // R7: run past wrap
    for (int k = 0; k < 520; k++) begin
      fire(bit2(5, 13), '0, 0);
      chk("R7 wrap evt", 64'(evt_num), 64'(exp_evt));
      exp_evt = exp_evt + EW'(1);
      release_slot(0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule